// File: doc/BRIEF.md
# Renaming Issue Unit with Reservation Stations

This block sits in front of one pipelined execution unit and lets register-to-register instructions run out of program order. Instructions arrive in order on an issue port and each one takes a free reservation station. The station's identifier becomes the rename tag for the instruction's destination register. The block keeps a status table that holds, for every register, the tag of its newest pending producer.

Source operands come from the register file when they are already resolved. When they are not, the station keeps the producer's tag and watches the single result broadcast bus until that tag appears. A station whose operands are both present may be sent to the execution unit, whatever its position in program order. The unit has a fixed two-cycle latency and broadcasts each result with its tag. A broadcast updates the architectural register only while it is still the newest producer of that register. Because of this, write-after-read and write-after-write conflicts never hold up issue. Issue waits only for a free station.

Top module: `rsu_issue_unit`

## Requirements
- R1: After reset `iss_ready` is 1, `dsp_valid` and `cdb_valid` are 0, no station is busy, and every architectural register reads as 0.
- R2: Operation codes on `iss_op`: 0 gives rs1+rs2, 1 gives rs1-rs2, 2 gives rs1 XOR rs2, and 3 loads `iss_imm`. Arithmetic wraps modulo 2^W. For code 3 the immediate travels as the first dispatch operand, and the second operand is 0.
- R3: A station is dispatched only when both of its operands hold values. The dispatch port shows that station's opcode, both operand values and its tag.
- R4: Every dispatch is followed exactly two cycles later by one broadcast (`cdb_valid`=1) that carries the same tag and the result of the dispatched operation.
- R5: Station i (counting from 0) owns tag i+1, and tag 0 means "value present". A new instruction takes the lowest-numbered free station.
- R6: When several stations are ready in the same cycle, the lowest-numbered one is dispatched first, even if it is younger in program order. Stations may dispatch in any order relative to program order.
- R7: A reader issued before a later writer of the same register receives the older value, even when the later writer executes first.
- R8: A broadcast writes a register only when that register's status entry still holds the broadcast tag, and it then clears the entry. After all instructions drain, each register holds the value of the last writer in program order.
- R9: An instruction accepted in the same cycle as the broadcast of its source's producer takes the broadcast value.
- R10: `iss_ready` is 1 whenever at least one station is free. A dependent burst larger than the pool stalls issue but loses no instruction. A back-to-back burst of independent writes to one register never stalls.
- R11: At most one station is dispatched per cycle. A dispatched station stays busy until its own tag is broadcast, and it is freed then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation code (R2) |
| iss_rd | input | 3 | Destination register |
| iss_rs1 | input | 3 | First source register |
| iss_rs2 | input | 3 | Second source register |
| iss_imm | input | 16 | Immediate for the load operation |
| iss_ready | output | 1 | A station is free; issue is accepted when valid and ready |
| dsp_valid | output | 1 | A station is sent to the execution unit this cycle |
| dsp_tag | output | 3 | Tag of the dispatched station |
| dsp_op | output | 2 | Operation of the dispatched station |
| dsp_a | output | 16 | First operand value |
| dsp_b | output | 16 | Second operand value |
| cdb_valid | output | 1 | Result broadcast valid |
| cdb_tag | output | 3 | Tag of the broadcast result |
| cdb_value | output | 16 | Broadcast result value |

## Verification
The arithmetic is swept with every operation code over operand pairs at the wrap boundaries (zero, all ones, sign edge). Each pair is issued right behind its two producing loads, so that both operands must be caught from the broadcast bus and never read from the register file. Hand-built sequences separate the renaming cases from one another:
- an older reader followed by a newer writer shows whether the reader keeps the old value;
- two stations woken by the same broadcast show whether the lower index wins;
- a consumer accepted during its producer's broadcast shows whether the bypass works;
- a dependent burst larger than the pool shows whether a stall loses work;
- independent rewrites of one register show whether a false dependence blocks issue.

Every broadcast is compared against a bench-computed result of the dispatch two cycles earlier.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_LDI = 2'd3
  } rsu_op_e;

endpackage

// File: rtl/rsu_pick.sv
module rsu_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  // R11: never more than one winner
  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: a winner is always a requester
  assert_grant_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/rsu_regstat.sv
module rsu_regstat #(
  parameter int unsigned W    = 16,
  parameter int unsigned NREG = 8,
  parameter int unsigned TW   = 3,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rs1,
  input  logic [AW-1:0] rs2,
  input  logic          iss_fire,
  input  logic [AW-1:0] iss_rd,
  input  logic [TW-1:0] iss_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [W-1:0]  cdb_val,
  output logic [W-1:0]  src1_v,
  output logic [TW-1:0] src1_q,
  output logic [W-1:0]  src2_v,
  output logic [TW-1:0] src2_q
);

  logic [W-1:0]    rf   [NREG];
  logic [TW-1:0]   stat [NREG];
  logic [NREG-1:0] commit;

  // Resolve one source: register file, same-cycle broadcast, or pending tag.
  function automatic logic [W+TW-1:0] resolve(input logic [TW-1:0] q,
                                              input logic [W-1:0] v,
                                              input logic bv,
                                              input logic [TW-1:0] bt,
                                              input logic [W-1:0] bval);
    if (q == '0)            return {v, {TW{1'b0}}};
    else if (bv && bt == q) return {bval, {TW{1'b0}}};
    else                    return {{W{1'b0}}, q};
  endfunction

  always_comb begin
    {src1_v, src1_q} = resolve(stat[rs1], rf[rs1], cdb_valid, cdb_tag, cdb_val);
    {src2_v, src2_q} = resolve(stat[rs2], rf[rs2], cdb_valid, cdb_tag, cdb_val);
    for (int r = 0; r < NREG; r++)
      commit[r] = cdb_valid && (stat[r] != '0) && (stat[r] == cdb_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        rf[r]   <= '0;
        stat[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (commit[r]) begin
          rf[r]   <= cdb_val;
          stat[r] <= '0;
        end
        if (iss_fire && iss_rd == AW'(r))
          stat[r] <= iss_tag;
      end
    end
  end

  // R8: a tag is the newest producer of at most one register
  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit));

  // R5: a renamed register never points at the "present" tag
  assert_rename_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> iss_tag != '0);

endmodule

// File: rtl/rsu_station.sv
module rsu_station #(
  parameter int unsigned W     = 16,
  parameter int unsigned TW    = 3,
  parameter int unsigned MYTAG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  rsu_pkg::rsu_op_e in_op,
  input  logic [W-1:0]     in_vj,
  input  logic [TW-1:0]    in_qj,
  input  logic [W-1:0]     in_vk,
  input  logic [TW-1:0]    in_qk,
  input  logic             cdb_valid,
  input  logic [TW-1:0]    cdb_tag,
  input  logic [W-1:0]     cdb_val,
  input  logic             grant,
  output logic             busy,
  output logic             ready,
  output rsu_pkg::rsu_op_e op,
  output logic [W-1:0]     vj,
  output logic [W-1:0]     vk
);

  logic          sent;
  logic [TW-1:0] qj, qk;
  logic          hit_j, hit_k, own_done;

  assign hit_j    = cdb_valid && qj != '0 && qj == cdb_tag;
  assign hit_k    = cdb_valid && qk != '0 && qk == cdb_tag;
  assign own_done = cdb_valid && busy && cdb_tag == TW'(MYTAG);
  assign ready    = busy && !sent && qj == '0 && qk == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sent <= 1'b0;
      op   <= rsu_pkg::OP_ADD;
      vj   <= '0;
      vk   <= '0;
      qj   <= '0;
      qk   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      sent <= 1'b0;
      op   <= in_op;
      vj   <= in_vj;
      qj   <= in_qj;
      vk   <= in_vk;
      qk   <= in_qk;
    end else begin
      if (hit_j) begin
        vj <= cdb_val;
        qj <= '0;
      end
      if (hit_k) begin
        vk <= cdb_val;
        qk <= '0;
      end
      if (grant)    sent <= 1'b1;
      if (own_done) busy <= 1'b0;
    end
  end

  // R3: only a station holding both operand values is sent
  assert_grant_has_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (busy && !sent && qj == '0 && qk == '0));

  // R10: allocation only into a free station
  assert_alloc_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy);

  // R11: a dispatched station stays busy until its result is broadcast
  assert_hold_after_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy);

endmodule

// File: rtl/rsu_exec.sv
module rsu_exec #(
  parameter int unsigned W  = 16,
  parameter int unsigned TW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  rsu_pkg::rsu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [TW-1:0]    tag,
  output logic             res_v,
  output logic [TW-1:0]    res_tag,
  output logic [W-1:0]     res_val
);

  function automatic logic [W-1:0] alu(input rsu_pkg::rsu_op_e o,
                                       input logic [W-1:0] x,
                                       input logic [W-1:0] y);
    case (o)
      rsu_pkg::OP_ADD: return x + y;
      rsu_pkg::OP_SUB: return x - y;
      rsu_pkg::OP_XOR: return x ^ y;
      default:         return x;
    endcase
  endfunction

  logic          s1_v;
  logic [TW-1:0] s1_tag;
  logic [W-1:0]  s1_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_tag  <= '0;
      s1_val  <= '0;
      res_v   <= 1'b0;
      res_tag <= '0;
      res_val <= '0;
    end else begin
      s1_v    <= go;
      s1_tag  <= tag;
      s1_val  <= alu(op, a, b);
      res_v   <= s1_v;
      res_tag <= s1_tag;
      res_val <= s1_val;
    end
  end

  // R4: the result of a dispatch appears exactly two cycles later
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ##1 (res_v && res_tag == $past(tag, 2)));

endmodule

// File: rtl/rsu_issue_unit.sv
module rsu_issue_unit #(
  parameter int unsigned W    = 16,
  parameter int unsigned NREG = 8,
  parameter int unsigned NRS  = 4,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned TW  = $clog2(NRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [AW-1:0] iss_rd,
  input  logic [AW-1:0] iss_rs1,
  input  logic [AW-1:0] iss_rs2,
  input  logic [W-1:0]  iss_imm,
  output logic          iss_ready,
  output logic          dsp_valid,
  output logic [TW-1:0] dsp_tag,
  output logic [1:0]    dsp_op,
  output logic [W-1:0]  dsp_a,
  output logic [W-1:0]  dsp_b,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [W-1:0]  cdb_value
);

  logic [NRS-1:0]   busy, ready, grant, free_oh, alloc;
  rsu_pkg::rsu_op_e st_op [NRS];
  logic [W-1:0]     st_vj [NRS];
  logic [W-1:0]     st_vk [NRS];
  logic             iss_fire;
  logic [TW-1:0]    new_tag;
  rsu_pkg::rsu_op_e in_op, disp_op;
  logic [W-1:0]     s1_v, s2_v, in_vj, in_vk;
  logic [TW-1:0]    s1_q, s2_q, in_qj, in_qk;

  assign in_op     = rsu_pkg::rsu_op_e'(iss_op);
  assign iss_ready = |(~busy);
  assign iss_fire  = iss_valid && iss_ready;
  assign alloc     = free_oh & {NRS{iss_fire}};

  always_comb begin
    new_tag = '0;
    for (int i = 0; i < NRS; i++)
      if (free_oh[i]) new_tag = TW'(i + 1);
  end

  // The load operation carries its immediate as the first operand.
  always_comb begin
    if (in_op == rsu_pkg::OP_LDI) begin
      in_vj = iss_imm;
      in_qj = '0;
      in_vk = '0;
      in_qk = '0;
    end else begin
      in_vj = s1_v;
      in_qj = s1_q;
      in_vk = s2_v;
      in_qk = s2_q;
    end
  end

  rsu_pick #(.N(NRS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req(~busy), .grant(free_oh)
  );

  rsu_pick #(.N(NRS)) u_disp (
    .clk(clk), .rst_n(rst_n), .req(ready), .grant(grant)
  );

  rsu_regstat #(.W(W), .NREG(NREG), .TW(TW), .AW(AW)) u_regstat (
    .clk(clk), .rst_n(rst_n), .rs1(iss_rs1), .rs2(iss_rs2),
    .iss_fire(iss_fire), .iss_rd(iss_rd), .iss_tag(new_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_value),
    .src1_v(s1_v), .src1_q(s1_q), .src2_v(s2_v), .src2_q(s2_q)
  );

  for (genvar g = 0; g < NRS; g++) begin : g_rs
    rsu_station #(.W(W), .TW(TW), .MYTAG(g + 1)) u_rs (
      .clk(clk), .rst_n(rst_n), .alloc(alloc[g]), .in_op(in_op),
      .in_vj(in_vj), .in_qj(in_qj), .in_vk(in_vk), .in_qk(in_qk),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_value),
      .grant(grant[g]), .busy(busy[g]), .ready(ready[g]),
      .op(st_op[g]), .vj(st_vj[g]), .vk(st_vk[g])
    );
  end

  always_comb begin
    dsp_tag = '0;
    disp_op = rsu_pkg::OP_ADD;
    dsp_a   = '0;
    dsp_b   = '0;
    for (int i = 0; i < NRS; i++) begin
      if (grant[i]) begin
        dsp_tag = TW'(i + 1);
        disp_op = st_op[i];
        dsp_a   = st_vj[i];
        dsp_b   = st_vk[i];
      end
    end
  end

  assign dsp_valid = |grant;
  assign dsp_op    = disp_op;

  rsu_exec #(.W(W), .TW(TW)) u_exec (
    .clk(clk), .rst_n(rst_n), .go(dsp_valid), .op(disp_op),
    .a(dsp_a), .b(dsp_b), .tag(dsp_tag),
    .res_v(cdb_valid), .res_tag(cdb_tag), .res_val(cdb_value)
  );

  // R5: dispatched tags name a real station
  assert_dispatch_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (dsp_tag != '0 && dsp_tag <= TW'(NRS)));

  // R11: a broadcast always belongs to a station still holding it
  assert_bcast_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> busy != '0);

endmodule

// File: tb/rsu_issue_unit_tb.sv
`timescale 1ns/1ps
module rsu_issue_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = '0;
  logic [2:0]  iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0;
  logic [15:0] iss_imm = '0;
  logic        iss_ready, dsp_valid, cdb_valid;
  logic [2:0]  dsp_tag, cdb_tag;
  logic [1:0]  dsp_op;
  logic [15:0] dsp_a, dsp_b, cdb_value;

  int checks = 0;
  int errors = 0;
  int stalls = 0;

  always #2.5 clk = ~clk;

  rsu_issue_unit u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_imm(iss_imm),
    .iss_ready(iss_ready), .dsp_valid(dsp_valid), .dsp_tag(dsp_tag),
    .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  function automatic logic [15:0] model(input logic [1:0] op,
                                        input logic [15:0] a,
                                        input logic [15:0] b);
    int x, y;
    x = int'(a);
    y = int'(b);
    case (op)
      2'd0: return 16'((x + y) % 65536);
      2'd1: return 16'((x - y + 65536) % 65536);
      2'd2: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // dispatch log and broadcast monitor
  logic [1:0]  lg_op  [512];
  logic [15:0] lg_a   [512];
  logic [2:0]  lg_tag [512];
  int          lg_n = 0;
  logic        h1v = 0, h2v = 0;
  logic [1:0]  h1o, h2o;
  logic [15:0] h1a, h1b, h2a, h2b;
  logic [2:0]  h1t, h2t;

  always @(negedge clk) begin
    if (rst_n) begin
      check(cdb_valid == h2v, "R4 broadcast timing", int'(cdb_valid), int'(h2v));
      if (cdb_valid && h2v) begin
        check(cdb_tag == h2t, "R4 broadcast tag", int'(cdb_tag), int'(h2t));
        check(cdb_value == model(h2o, h2a, h2b), "R2 broadcast value",
              int'(cdb_value), int'(model(h2o, h2a, h2b)));
      end
      h2v = h1v; h2o = h1o; h2a = h1a; h2b = h1b; h2t = h1t;
      h1v = dsp_valid; h1o = dsp_op; h1a = dsp_a; h1b = dsp_b; h1t = dsp_tag;
      if (dsp_valid && lg_n < 512) begin
        lg_op[lg_n] = dsp_op;
        lg_a[lg_n] = dsp_a;
        lg_tag[lg_n] = dsp_tag;
        lg_n++;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [2:0] rd,
                       input logic [2:0] a, input logic [2:0] b,
                       input logic [15:0] imm);
    iss_valid = 1'b1; iss_op = op; iss_rd = rd;
    iss_rs1 = a; iss_rs2 = b; iss_imm = imm;
    while (!iss_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  // read register x through a dispatch of r7 = x + x
  task automatic probe(input logic [2:0] x, input logic [15:0] exp, input string req);
    int guard;
    issue(2'd0, 3'd7, x, x, 16'd0);
    guard = 0;
    while (!dsp_valid && guard < 30) begin
      @(negedge clk);
      guard++;
    end
    check(dsp_valid && dsp_a == exp, req, int'(dsp_a), int'(exp));
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] va [5];
    logic [15:0] vb [5];
    int n0;
    va[0] = 16'h0000; vb[0] = 16'h0000;
    va[1] = 16'h0001; vb[1] = 16'h0002;
    va[2] = 16'hFFFF; vb[2] = 16'h0001;
    va[3] = 16'h8000; vb[3] = 16'h7FFF;
    va[4] = 16'h1234; vb[4] = 16'hABCD;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(iss_ready == 1'b1, "R1 ready after reset", int'(iss_ready), 1);
    check(dsp_valid == 1'b0, "R1 no dispatch after reset", int'(dsp_valid), 0);
    check(cdb_valid == 1'b0, "R1 no broadcast after reset", int'(cdb_valid), 0);
    for (int r = 0; r < 7; r++) probe(3'(r), 16'd0, "R1 register zero");

    // R2 sweep: operands arrive only from the broadcast bus
    for (int op = 0; op < 4; op++) begin
      for (int p = 0; p < 5; p++) begin
        issue(2'd3, 3'd1, 3'd0, 3'd0, va[p]);
        issue(2'd3, 3'd2, 3'd0, 3'd0, vb[p]);
        issue(2'(op), 3'd3, 3'd1, 3'd2, va[p]);
        drain();
        probe(3'd3, model(2'(op), va[p], vb[p]), "R2 operation result");
      end
    end

    // R7/R8/R6: older reader, newer writer that executes first
    n0 = lg_n;
    issue(2'd3, 3'd1, 3'd0, 3'd0, 16'd3);
    issue(2'd0, 3'd2, 3'd1, 3'd1, 16'd0);
    issue(2'd3, 3'd1, 3'd0, 3'd0, 16'd9);
    drain();
    check(lg_op[n0 + 1] == 2'd3 && lg_a[n0 + 1] == 16'd9, "R6 younger write first",
          int'(lg_a[n0 + 1]), 9);
    check(lg_op[n0 + 2] == 2'd0 && lg_a[n0 + 2] == 16'd3, "R7 reader keeps old value",
          int'(lg_a[n0 + 2]), 3);
    probe(3'd2, 16'd6, "R7 reader result");
    probe(3'd1, 16'd9, "R8 last writer wins");

    // R5/R6: two stations woken by one broadcast
    n0 = lg_n;
    issue(2'd3, 3'd6, 3'd0, 3'd0, 16'd1);
    issue(2'd0, 3'd2, 3'd6, 3'd6, 16'd0);
    issue(2'd1, 3'd3, 3'd6, 3'd6, 16'd0);
    drain();
    check(lg_tag[n0] == 3'd1, "R5 first station tag", int'(lg_tag[n0]), 1);
    check(lg_tag[n0 + 1] == 3'd2 && lg_op[n0 + 1] == 2'd0, "R6 lowest index first",
          int'(lg_tag[n0 + 1]), 2);
    check(lg_tag[n0 + 2] == 3'd3 && lg_op[n0 + 2] == 2'd1, "R6 next index second",
          int'(lg_tag[n0 + 2]), 3);
    probe(3'd2, 16'd2, "R5 add result");
    probe(3'd3, 16'd0, "R5 sub result");

    // R9: consumer accepted during its producer's broadcast
    issue(2'd3, 3'd4, 3'd0, 3'd0, 16'd11);
    while (!cdb_valid) @(negedge clk);
    issue(2'd0, 3'd5, 3'd4, 3'd4, 16'd0);
    drain();
    probe(3'd5, 16'd22, "R9 same-cycle capture");

    // R10/R11: dependent burst larger than the pool
    stalls = 0;
    issue(2'd3, 3'd0, 3'd0, 3'd0, 16'd1);
    for (int k = 0; k < 7; k++) issue(2'd0, 3'd0, 3'd0, 3'd0, 16'd0);
    check(stalls > 0, "R10 full pool stalls", stalls, 1);
    drain();
    probe(3'd0, 16'd128, "R11 burst result");

    // R10: independent rewrites of one register never stall
    stalls = 0;
    for (int k = 0; k < 8; k++) issue(2'd3, 3'd3, 3'd0, 3'd0, 16'(10 + k));
    check(stalls == 0, "R10 no false-dependence stall", stalls, 0);
    drain();
    probe(3'd3, 16'd17, "R8 final rewrite value");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule